// File: doc/BRIEF.md
# Addressed Serial Command Decoder

This block is the slave end of a three-wire configuration port with a chip-select, a serial clock and a data line. While select is low it samples the data line on each rising serial-clock edge, least significant bit first, and builds 8-bit bytes. All three inputs are synchronised into the core clock domain before use. The first byte of each select-low period is a header. Its two low bits must equal the chip ID pins, or the whole sequence is dropped.

The header's upper bits pick one of five command kinds:
- a three-byte clock-setting command;
- a channel-setup sequence of seven-byte records per channel, closed by a 0xFF footer;
- a per-channel control sequence, which starts at a begin-channel byte and carries two-byte words;
- a conferencing sequence with the same layout as the control sequence;
- single-byte power-up and power-down commands.

Every completed byte that is accepted writes straight into a configuration register file, whose contents are presented on flat output buses. A one-cycle done pulse marks each command that completes.

The decoder is used by a host controller to configure several channels of a voice-processing datapath. How the configured values affect that datapath lies outside this block.

Top module: `cmd_port_decoder`

## Requirements
- R1: A data bit is taken on each rising serial-clock edge while select is low, least significant bit first, and every eight bits form one byte. Serial-clock edges while select is high have no effect, and configuration outputs change only after a completed byte.
- R2: When select rises with a partial byte pending, those bits are discarded. The next select-low period starts again with a header.
- R3: A header whose bits [1:0] differ from `chip_id` causes the rest of the sequence to be ignored, with no register change and no done pulse.
- R4: Header pattern 01ffffAA is the clock command, and it loads `clk_div` from header bits [5:2]. The second byte loads `pll_mul` from bits [7:1] and `pll_div[5]` from bit 0. The third byte loads `pll_div[4:0]` from bits [7:3] and `pll_post` from bits [2:0], and then `cmd_done` pulses. Any further bytes in that period are ignored.
- R5: Header 000100AA sets `power_on` to 1 and header 000010AA clears it. Either one pulses `cmd_done` one cycle later.
- R6: Header 000000AA starts channel setup. Seven-byte records go to channel 0, 1, 2 and so on in order, and byte k of channel c appears at `chan_setup[(c*7+k)*8 +: 8]`. A 0xFF in the first position of a record ends the sequence and pulses `cmd_done`. If select rises without that footer, no done pulse is produced.
- R7: Header 001100AA is followed by a begin-channel byte and then two-byte words. The first byte of each word goes to `chan_ctrl[c*16+8 +: 8]` and the second to `chan_ctrl[c*16 +: 8]`. The channel c starts at the begin value and advances after each word.
- R8: Header 001000AA is decoded exactly as in R7, but writes `chan_conf`.
- R9: Records addressed beyond channel NUM_CH-1 are ignored, including a begin-channel value of NUM_CH or more.
- R10: A control or conferencing sequence pulses `cmd_done` once, when select rises on a byte boundary after the begin-channel byte. A select rise in the middle of a byte gives no pulse, but bytes already completed stay written.
- R11: After reset, every `chan_ctrl` word is 0x3670 and `chan_conf`, `chan_setup` and the clock fields are zero. `power_on` is 1 and `cmd_done` is 0.
- R12: A matching header with an unknown command pattern, for example 0x82 with ID 2, is ignored together with the rest of its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_id | input | 2 | This device's address |
| sel_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| clk_div | output | 4 | Line-clock divider field |
| pll_mul | output | 7 | Frequency multiplier field |
| pll_div | output | 6 | Frequency divider field |
| pll_post | output | 3 | Post-divider select field |
| power_on | output | 1 | Power state, 1 = up |
| chan_setup | output | NUM_CH*56 | Seven setup bytes per channel |
| chan_ctrl | output | NUM_CH*16 | Control word per channel |
| chan_conf | output | NUM_CH*16 | Conferencing word per channel |
| cmd_done | output | 1 | One-cycle pulse at command completion |

## Verification
A bit counter that has slipped is visible at the ports within one byte time, because every later field lands shifted and the bench's exact-value compare after that frame reports it. A wrong sequencer state or channel index shows up as a write to the wrong channel slice, or as a missing or extra `cmd_done` pulse, in the same frame. A lost ID or footer decision appears as a changed `power_on` or setup byte at the next snapshot. The bench snapshots every output after every frame, so a fault never goes unseen for more than one frame.

// File: rtl/cmd_port_pkg.sv
package cmd_port_pkg;
    localparam int BYTE_W      = 8;
    localparam int REC_BYTES   = 7;
    localparam int WORD_W      = 16;
    localparam int IDX_W       = 3;
    localparam int CHAN_IDX_W  = 8;
    localparam int DIV_W       = 4;
    localparam int MUL_W       = 7;
    localparam int DVD_W       = 6;
    localparam int POST_W      = 3;

    localparam logic [5:0] OP_SETUP   = 6'b000000;
    localparam logic [5:0] OP_CTRL    = 6'b001100;
    localparam logic [5:0] OP_CONF    = 6'b001000;
    localparam logic [5:0] OP_PWR_UP  = 6'b000100;
    localparam logic [5:0] OP_PWR_DN  = 6'b000010;
    localparam logic [1:0] OP_CLK_TAG = 2'b01;
    localparam logic [7:0] SETUP_FOOTER = 8'hFF;
    localparam logic [15:0] CTRL_RESET  = 16'h3670;

    typedef enum logic [2:0] {
        ST_HDR, ST_CLK_B2, ST_CLK_B3, ST_SETUP, ST_BEGIN, ST_PAIR, ST_SKIP
    } seq_state_e;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_CLK_B1, TGT_CLK_B2, TGT_CLK_B3,
        TGT_PWR, TGT_SETUP, TGT_CTRL, TGT_CONF
    } wr_target_e;

    typedef struct packed {
        wr_target_e              tgt;
        logic [CHAN_IDX_W-1:0]   chan;
        logic [IDX_W-1:0]        idx;
        logic [BYTE_W-1:0]       data;
    } cfg_wr_t;
endpackage

// File: rtl/cmd_byte_rx.sv
module cmd_byte_rx
    import cmd_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              frame_end,
    output logic              aligned
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [SYNC_STAGES:0]   sclk_pipe;
        logic [SYNC_STAGES:0]   sel_pipe;
        logic [SYNC_STAGES-1:0] sdi_pipe;
        logic [BYTE_W-1:0]      shreg;
        logic [CNT_W-1:0]       cnt;
        logic                   byte_vld;
        logic [BYTE_W-1:0]      byte_data;
        logic                   frame_end;
        logic                   aligned;
    } rx_state_t;

    rx_state_t q, d;

    logic sclk_now, sclk_old, sel_now, sel_old, sdi_now;

    always_comb begin
        sclk_now = q.sclk_pipe[SYNC_STAGES-1];
        sclk_old = q.sclk_pipe[SYNC_STAGES];
        sel_now  = q.sel_pipe[SYNC_STAGES-1];
        sel_old  = q.sel_pipe[SYNC_STAGES];
        sdi_now  = q.sdi_pipe[SYNC_STAGES-1];

        d = q;
        d.sclk_pipe = {q.sclk_pipe[SYNC_STAGES-1:0], sclk};
        d.sel_pipe  = {q.sel_pipe[SYNC_STAGES-1:0], sel_n};
        d.sdi_pipe  = {q.sdi_pipe[SYNC_STAGES-2:0], sdi};
        d.byte_vld  = 1'b0;
        d.frame_end = 1'b0;

        if (sel_now) begin
            d.cnt = '0;
            if (!sel_old) begin
                d.frame_end = 1'b1;
                d.aligned   = (q.cnt == '0);
            end
        end else if (sclk_now && !sclk_old) begin
            d.shreg = {sdi_now, q.shreg[BYTE_W-1:1]};
            d.cnt   = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                d.byte_vld  = 1'b1;
                d.byte_data = {sdi_now, q.shreg[BYTE_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.sel_pipe <= '1;
        end else begin
            q <= d;
        end
    end

    assign byte_vld  = q.byte_vld;
    assign byte_data = q.byte_data;
    assign frame_end = q.frame_end;
    assign aligned   = q.aligned;
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
    import cmd_port_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chip_id,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              frame_end,
    input  logic              aligned,
    output cfg_wr_t           wr,
    output logic              cmd_done,
    output logic              at_header
);
    localparam int CH_W = $clog2(NUM_CH);
    localparam int CI_W = CH_W + 1;
    localparam logic [CI_W-1:0] CH_END = CI_W'(NUM_CH);

    typedef struct packed {
        seq_state_e       st;
        logic             is_conf;
        logic [CI_W-1:0]  chan;
        logic [IDX_W-1:0] idx;
        logic             done;
    } seq_state_t;

    seq_state_t q, d;
    logic chan_ok;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        wr      = '0;
        wr.tgt  = TGT_NONE;
        wr.data = byte_data;
        wr.chan = CHAN_IDX_W'(q.chan);
        wr.idx  = q.idx;
        chan_ok = (q.chan < CH_END);

        if (frame_end) begin
            d.st   = ST_HDR;
            d.idx  = '0;
            d.done = aligned && (q.st == ST_PAIR);
        end else if (byte_vld) begin
            case (q.st)
                ST_HDR: begin
                    if (byte_data[1:0] != chip_id) begin
                        d.st = ST_SKIP;
                    end else if (byte_data[7:6] == OP_CLK_TAG) begin
                        wr.tgt = TGT_CLK_B1;
                        d.st   = ST_CLK_B2;
                    end else begin
                        case (byte_data[7:2])
                            OP_SETUP: begin
                                d.st   = ST_SETUP;
                                d.chan = '0;
                                d.idx  = '0;
                            end
                            OP_CTRL: begin
                                d.st      = ST_BEGIN;
                                d.is_conf = 1'b0;
                            end
                            OP_CONF: begin
                                d.st      = ST_BEGIN;
                                d.is_conf = 1'b1;
                            end
                            OP_PWR_UP, OP_PWR_DN: begin
                                wr.tgt  = TGT_PWR;
                                wr.data = {7'd0, byte_data[7:2] == OP_PWR_UP};
                                d.done  = 1'b1;
                                d.st    = ST_SKIP;
                            end
                            default: d.st = ST_SKIP;
                        endcase
                    end
                end
                ST_CLK_B2: begin
                    wr.tgt = TGT_CLK_B2;
                    d.st   = ST_CLK_B3;
                end
                ST_CLK_B3: begin
                    wr.tgt = TGT_CLK_B3;
                    d.done = 1'b1;
                    d.st   = ST_SKIP;
                end
                ST_SETUP: begin
                    if (q.idx == '0 && byte_data == SETUP_FOOTER) begin
                        d.done = 1'b1;
                        d.st   = ST_SKIP;
                    end else begin
                        if (chan_ok) wr.tgt = TGT_SETUP;
                        if (q.idx == IDX_W'(REC_BYTES - 1)) begin
                            d.idx = '0;
                            if (chan_ok) d.chan = q.chan + 1'b1;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
                ST_BEGIN: begin
                    d.chan = (int'(byte_data) >= NUM_CH) ? CH_END : byte_data[CI_W-1:0];
                    d.idx  = '0;
                    d.st   = ST_PAIR;
                end
                ST_PAIR: begin
                    if (chan_ok) wr.tgt = q.is_conf ? TGT_CONF : TGT_CTRL;
                    if (q.idx != '0) begin
                        d.idx = '0;
                        if (chan_ok) d.chan = q.chan + 1'b1;
                    end else begin
                        d.idx = IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_HDR;
        end else begin
            q <= d;
        end
    end

    assign cmd_done  = q.done;
    assign at_header = (q.st == ST_HDR);
endmodule

// File: rtl/cmd_cfg_regs.sv
module cmd_cfg_regs
    import cmd_port_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  cfg_wr_t                           wr,
    output logic [DIV_W-1:0]                  clk_div,
    output logic [MUL_W-1:0]                  pll_mul,
    output logic [DVD_W-1:0]                  pll_div,
    output logic [POST_W-1:0]                 pll_post,
    output logic                              power_on,
    output logic [NUM_CH*REC_BYTES*BYTE_W-1:0] chan_setup,
    output logic [NUM_CH*WORD_W-1:0]          chan_ctrl,
    output logic [NUM_CH*WORD_W-1:0]          chan_conf
);
    typedef struct packed {
        logic [NUM_CH-1:0][REC_BYTES-1:0][BYTE_W-1:0] setup;
        logic [NUM_CH-1:0][WORD_W-1:0]                ctrl;
        logic [NUM_CH-1:0][WORD_W-1:0]                conf;
        logic [DIV_W-1:0]                             div;
        logic [MUL_W-1:0]                             mul;
        logic [DVD_W-1:0]                             dvd;
        logic [POST_W-1:0]                            post;
        logic                                         pwr;
    } cfg_state_t;

    cfg_state_t q, d;

    always_comb begin
        d = q;
        case (wr.tgt)
            TGT_CLK_B1: d.div = wr.data[5:2];
            TGT_CLK_B2: begin
                d.mul    = wr.data[7:1];
                d.dvd[5] = wr.data[0];
            end
            TGT_CLK_B3: begin
                d.dvd[4:0] = wr.data[7:3];
                d.post     = wr.data[2:0];
            end
            TGT_PWR: d.pwr = wr.data[0];
            default: ;
        endcase
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr.chan == CHAN_IDX_W'(c)) begin
                for (int k = 0; k < REC_BYTES; k++) begin
                    if (wr.tgt == TGT_SETUP && wr.idx == IDX_W'(k))
                        d.setup[c][k] = wr.data;
                end
                if (wr.tgt == TGT_CTRL) begin
                    if (wr.idx == '0) d.ctrl[c][15:8] = wr.data;
                    else              d.ctrl[c][7:0]  = wr.data;
                end
                if (wr.tgt == TGT_CONF) begin
                    if (wr.idx == '0) d.conf[c][15:8] = wr.data;
                    else              d.conf[c][7:0]  = wr.data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.pwr <= 1'b1;
            for (int c = 0; c < NUM_CH; c++) q.ctrl[c] <= CTRL_RESET;
        end else begin
            q <= d;
        end
    end

    assign clk_div    = q.div;
    assign pll_mul    = q.mul;
    assign pll_div    = q.dvd;
    assign pll_post   = q.post;
    assign power_on   = q.pwr;
    assign chan_setup = q.setup;
    assign chan_ctrl  = q.ctrl;
    assign chan_conf  = q.conf;
endmodule

// File: rtl/cmd_port_decoder.sv
module cmd_port_decoder
    import cmd_port_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         chip_id,
    input  logic                               sel_n,
    input  logic                               sclk,
    input  logic                               sdi,
    output logic [DIV_W-1:0]                   clk_div,
    output logic [MUL_W-1:0]                   pll_mul,
    output logic [DVD_W-1:0]                   pll_div,
    output logic [POST_W-1:0]                  pll_post,
    output logic                               power_on,
    output logic [NUM_CH*REC_BYTES*BYTE_W-1:0] chan_setup,
    output logic [NUM_CH*WORD_W-1:0]           chan_ctrl,
    output logic [NUM_CH*WORD_W-1:0]           chan_conf,
    output logic                               cmd_done
);
    logic              rx_byte_vld;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_frame_end;
    logic              rx_aligned;
    logic              seq_at_header;
    cfg_wr_t           seq_wr;

    cmd_byte_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .byte_vld  (rx_byte_vld),
        .byte_data (rx_byte),
        .frame_end (rx_frame_end),
        .aligned   (rx_aligned)
    );

    cmd_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_id   (chip_id),
        .byte_vld  (rx_byte_vld),
        .byte_data (rx_byte),
        .frame_end (rx_frame_end),
        .aligned   (rx_aligned),
        .wr        (seq_wr),
        .cmd_done  (cmd_done),
        .at_header (seq_at_header)
    );

    cmd_cfg_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (seq_wr),
        .clk_div    (clk_div),
        .pll_mul    (pll_mul),
        .pll_div    (pll_div),
        .pll_post   (pll_post),
        .power_on   (power_on),
        .chan_setup (chan_setup),
        .chan_ctrl  (chan_ctrl),
        .chan_conf  (chan_conf)
    );
endmodule

// File: rtl/cmd_port_checker.sv
module cmd_port_checker
    import cmd_port_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [1:0]                         chip_id,
    input logic                               at_header,
    input logic                               byte_vld,
    input logic [BYTE_W-1:0]                  byte_data,
    input logic                               power_on,
    input logic                               cmd_done,
    input logic [DIV_W+MUL_W+DVD_W+POST_W-1:0] clk_fields,
    input logic [NUM_CH*REC_BYTES*BYTE_W-1:0] chan_setup,
    input logic [NUM_CH*WORD_W-1:0]           chan_ctrl,
    input logic [NUM_CH*WORD_W-1:0]           chan_conf
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done); // R10

    AST_CFG_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> ($stable(chan_setup) && $stable(chan_ctrl) && $stable(chan_conf)
                       && $stable(clk_fields) && $stable(power_on))); // R1

    AST_ID_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (at_header && byte_vld && byte_data[1:0] != chip_id)
            |=> ($stable(power_on) && !cmd_done)); // R3

    AST_PWR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_header && byte_vld && byte_data == {6'b000100, chip_id})
            |=> (power_on && cmd_done)); // R5

    AST_PWR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (at_header && byte_vld && byte_data == {6'b000010, chip_id})
            |=> (!power_on && cmd_done)); // R5
endmodule

bind cmd_port_decoder cmd_port_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_id    (chip_id),
    .at_header  (seq_at_header),
    .byte_vld   (rx_byte_vld),
    .byte_data  (rx_byte),
    .power_on   (power_on),
    .cmd_done   (cmd_done),
    .clk_fields ({clk_div, pll_mul, pll_div, pll_post}),
    .chan_setup (chan_setup),
    .chan_ctrl  (chan_ctrl),
    .chan_conf  (chan_conf)
);

// File: tb/cmd_port_decoder_bench.sv
module cmd_port_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int HALF = 4;
    localparam logic [1:0] MY_ID = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic [3:0] clk_div;
    logic [6:0] pll_mul;
    logic [5:0] pll_div;
    logic [2:0] pll_post;
    logic power_on, cmd_done;
    logic [NCH*56-1:0] chan_setup;
    logic [NCH*16-1:0] chan_ctrl, chan_conf;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_port_decoder #(.NUM_CH(NCH)) u_cmd_port_decoder (
        .clk(clk), .rst_n(rst_n), .chip_id(MY_ID), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .clk_div(clk_div), .pll_mul(pll_mul), .pll_div(pll_div), .pll_post(pll_post),
        .power_on(power_on), .chan_setup(chan_setup), .chan_ctrl(chan_ctrl),
        .chan_conf(chan_conf), .cmd_done(cmd_done)
    );

    int checks = 0;
    int errors = 0;
    int done_seen = 0;

    // expected model, set by the test sequence from the requirements
    logic [NCH-1:0][15:0]     exp_ctrl;
    logic [NCH-1:0][15:0]     exp_conf;
    logic [NCH-1:0][6:0][7:0] exp_setup;
    logic [3:0] exp_div;
    logic [6:0] exp_mul;
    logic [5:0] exp_dvd;
    logic [2:0] exp_post;
    logic exp_pwr;
    int   exp_done;

    typedef struct {
        string                    tag;
        int                       done_cnt;
        logic [19:0]              clkf;
        logic                     pwr;
        logic [NCH*16-1:0]        ctrl;
        logic [NCH*16-1:0]        conf;
        logic [NCH*56-1:0]        setup;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic [7:0] tx_q[$];

    task automatic check(input string tag, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: counts done pulses and compares outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_done) done_seen++;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, "done count", 512'(done_seen), 512'(it.done_cnt));
                check(it.tag, "clock fields", 512'({clk_div, pll_mul, pll_div, pll_post}), 512'(it.clkf));
                check(it.tag, "power_on", 512'(power_on), 512'(it.pwr));
                check(it.tag, "chan_ctrl", 512'(chan_ctrl), 512'(it.ctrl));
                check(it.tag, "chan_conf", 512'(chan_conf), 512'(it.conf));
                check(it.tag, "chan_setup", 512'(chan_setup), 512'(it.setup));
            end
        end
    end

    task automatic expect_now(input string tag);
        sb_item_t it;
        repeat (12) @(negedge clk);
        it.tag      = tag;
        it.done_cnt = exp_done;
        it.clkf     = {exp_div, exp_mul, exp_dvd, exp_post};
        it.pwr      = exp_pwr;
        it.ctrl     = exp_ctrl;
        it.conf     = exp_conf;
        it.setup    = exp_setup;
        sb_q.push_back(it);
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        sdi = v;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_frame(input int extra_bits);
        @(negedge clk);
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        foreach (tx_q[i]) for (int b = 0; b < 8; b++) send_bit(tx_q[i][b]);
        for (int b = 0; b < extra_bits; b++) send_bit(1'b1);
        repeat (HALF) @(negedge clk);
        sel_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            exp_ctrl[c] = 16'h3670;
            exp_conf[c] = '0;
            exp_setup[c] = '0;
        end
        exp_div = '0; exp_mul = '0; exp_dvd = '0; exp_post = '0;
        exp_pwr = 1'b1; exp_done = 0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R11 reset defaults");

        // R1: serial clock toggles while deselected must do nothing
        for (int i = 0; i < 10; i++) begin
            sdi = i[0];
            repeat (HALF) @(negedge clk); sclk = 1'b1;
            repeat (HALF) @(negedge clk); sclk = 1'b0;
        end
        expect_now("R1 clock while deselected");

        tx_q = '{8'h0A};
        send_frame(0);
        exp_pwr = 1'b0; exp_done++;
        expect_now("R5 R1 power-down");

        tx_q = '{8'h11};
        send_frame(0);
        expect_now("R3 wrong chip id");

        tx_q = '{};
        send_frame(5);
        expect_now("R2 partial byte discarded");

        tx_q = '{8'h12};
        send_frame(0);
        exp_pwr = 1'b1; exp_done++;
        expect_now("R2 R5 power-up after partial");

        tx_q = '{8'h6E, 8'hAB, 8'hB3, 8'h0A};
        send_frame(0);
        exp_div = 4'hB; exp_mul = 7'h55; exp_dvd = 6'h36; exp_post = 3'h3; exp_done++;
        expect_now("R4 clock command, trailing byte ignored");

        tx_q = '{8'h32, 8'h06, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
        send_frame(0);
        exp_ctrl[6] = 16'h1234; exp_ctrl[7] = 16'h5678; exp_done++;
        expect_now("R7 R9 control words from begin channel 6");

        tx_q = '{8'h22, 8'h01, 8'hA5, 8'h5A, 8'h0F, 8'hF0};
        send_frame(0);
        exp_conf[1] = 16'hA55A; exp_conf[2] = 16'h0FF0; exp_done++;
        expect_now("R8 conferencing words");

        tx_q = '{8'h22, 8'h09, 8'h77, 8'h88};
        send_frame(0);
        exp_done++;
        expect_now("R9 begin channel out of range");

        tx_q = '{8'h02, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17,
                 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'hFF, 8'h0A};
        send_frame(0);
        for (int k = 0; k < 7; k++) begin
            exp_setup[0][k] = 8'h11 + 8'(k);
            exp_setup[1][k] = 8'h21 + 8'(k);
        end
        exp_done++;
        expect_now("R6 setup records with footer");

        tx_q = '{8'h02, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37};
        send_frame(0);
        for (int k = 0; k < 7; k++) exp_setup[0][k] = 8'h31 + 8'(k);
        expect_now("R6 setup without footer gives no done");

        tx_q = '{8'h82, 8'h0A};
        send_frame(0);
        expect_now("R12 unknown header ignored");

        tx_q = '{8'h32, 8'h00, 8'hC3};
        send_frame(3);
        exp_ctrl[0] = 16'hC370;
        expect_now("R10 unaligned end keeps bytes, no done");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule